// File: doc/BRIEF.md
# Timed Configuration-ROM Write Sequencer

This block programs a configuration ROM that is organised as 16-bit words and only accepts writes under a strict timing discipline. Before starting, a host pushes the data words into a small on-board FIFO. It then pulses `start` together with a first word index and a word count. The sequencer then runs the whole programming session on a simple single-strobe write bus without further help.

A session has three parts. First, one write to the ROM control register raises its write-enable bit, and the sequencer waits a long settling time. Next, each data word goes out as its own 16-bit write into a memory-mapped window, and a fixed gap follows every word. Last, a second control write drops write-enable, a second settling wait follows, and a one-cycle `done` pulse ends the session. The control register is never read. A shadow copy of it is kept, so both control writes change only the enable bit. All delays are parameters counted in clock cycles, so the same design serves silicon timing and short simulations.

Top module: `cfg_rom_prog`

## Requirements
- R1: After reset, `busy`, `done` and `bus_wr` are low.
- R2: A `start` sampled while idle produces, in the next cycle, a single write to `CTL_ADDR` whose data is the control shadow with bit 4 (mask 0x0010) set. `busy` is high from that cycle until the cycle after `done`.
- R3: The first data write comes exactly `ENABLE_WAIT` cycles after the enable write.
- R4: Data write k (k = 0, 1, ...) goes to byte address 0x1000 + 2*((start_index + k) mod 2^IDX_W). Its data is the k-th word pushed into the FIFO, in push order.
- R5: Consecutive data writes are exactly `WORD_WAIT` cycles apart. The disable write comes `WORD_WAIT` cycles after the last data write.
- R6: The disable write goes to `CTL_ADDR` with bit 4 cleared. Both control writes carry every other bit of the shadow, which starts at `CTL_INIT`, unchanged.
- R7: `done` is high for exactly one cycle, `ENABLE_WAIT` cycles after the disable write. `busy` is low in the following cycle.
- R8: A word count of zero still performs the enable write and the disable write `ENABLE_WAIT` cycles apart, followed by `done`, with no data write.
- R9: A `start` that arrives while `busy` is high is ignored. This includes the cycle in which `done` is high. Such a start adds no bus write and does not alter the running session.
- R10: `bus_wr` is never high in two consecutive cycles and never high while `busy` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load_push | input | 1 | Pushes `load_word` into the data FIFO |
| load_word | input | 16 | Data word to be programmed |
| start | input | 1 | Begins a session when idle |
| start_index | input | IDX_W | First ROM word index |
| word_total | input | CNT_W | Number of words to write |
| bus_wr | output | 1 | Single-cycle write strobe |
| bus_addr | output | 16 | Byte address of the write |
| bus_wdata | output | 16 | 16-bit write data |
| busy | output | 1 | High while a session runs |
| done | output | 1 | One-cycle end-of-session pulse |

## Verification
Two pairs of events can land in the same cycle. The first pair is a new `start` and the last cycle of a session: when `done` is high, `busy` is still high. The second pair is a host push and a FIFO pop during a data write. The bench sweeps every word count from zero to the FIFO depth, over start indices that include the wrap at the top of the index range. In each session it drives one extra start two cycles in and another exactly in the `done` cycle. It then judges the complete log of bus writes, including each write's cycle number, against expectations computed from the delay parameters. A second start that is wrongly accepted shows up as an extra write or a shifted `done`.

// File: rtl/cfgprog_pkg.sv
package cfgprog_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SET_WE,
        ST_WAIT_EN,
        ST_WRITE,
        ST_WAIT_WORD,
        ST_CLR_WE,
        ST_WAIT_DIS,
        ST_DONE
    } seq_state_e;

    localparam logic [15:0] WE_BIT_MASK = 16'h0010;
    localparam logic [15:0] WINDOW_BASE = 16'h1000;

    typedef struct packed {
        logic        wr;
        logic [15:0] addr;
        logic [15:0] data;
    } bus_req_t;

    function automatic logic [15:0] window_addr(input logic [15:0] idx);
        return WINDOW_BASE + {idx[14:0], 1'b0};
    endfunction

    function automatic logic [15:0] with_we(input logic [15:0] v, input logic on);
        return on ? (v | WE_BIT_MASK) : (v & ~WE_BIT_MASK);
    endfunction

endpackage

// File: rtl/cfgprog_fifo.sv
module cfgprog_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         push,
    input  logic [W-1:0] push_data,
    input  logic         pop,
    output logic [W-1:0] head
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] fill;
    logic          do_push, do_pop;

    assign do_push = push && (fill != CW'(DEPTH));
    assign do_pop  = pop && (fill != '0);
    assign head    = mem[rd_ptr];

    function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (do_push) wr_ptr <= bump(wr_ptr);
            if (do_pop)  rd_ptr <= bump(rd_ptr);
            if (do_push && !do_pop)      fill <= fill + 1'b1;
            else if (do_pop && !do_push) fill <= fill - 1'b1;
        end
    end
endmodule

// File: rtl/cfgprog_timer.sv
module cfgprog_timer #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expired
);
    logic [W-1:0] remain;

    assign expired = (remain == '0);

    always_ff @(posedge clk) begin
        if (rst)               remain <= '0;
        else if (load)         remain <= load_val;
        else if (remain != '0) remain <= remain - 1'b1;
    end
endmodule

// File: rtl/cfgprog_fsm.sv
module cfgprog_fsm
    import cfgprog_pkg::*;
#(
    parameter int          IDX_W       = 6,
    parameter int          CNT_W       = 4,
    parameter int          TMR_W       = 8,
    parameter int unsigned ENABLE_WAIT = 16,
    parameter int unsigned WORD_WAIT   = 4,
    parameter logic [15:0] CTL_ADDR    = 16'h0088,
    parameter logic [15:0] CTL_INIT    = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [IDX_W-1:0] start_index,
    input  logic [CNT_W-1:0] word_total,
    input  logic             expired,
    input  logic [15:0]      fifo_head,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             fifo_pop,
    output bus_req_t         req,
    output logic             busy,
    output logic             done
);
    // A wait is counted from its launching write; two cycles are spent in
    // the launching state and the state that follows the expiry.
    localparam logic [TMR_W-1:0] EN_LOAD   = TMR_W'(ENABLE_WAIT - 2);
    localparam logic [TMR_W-1:0] WORD_LOAD = TMR_W'(WORD_WAIT - 2);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [CNT_W-1:0] left;
    logic [15:0]      shadow;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            idx    <= '0;
            left   <= '0;
            shadow <= CTL_INIT;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    idx   <= start_index;
                    left  <= word_total;
                    state <= ST_SET_WE;
                end
                ST_SET_WE: begin
                    shadow <= with_we(shadow, 1'b1);
                    state  <= ST_WAIT_EN;
                end
                ST_WAIT_EN:
                    if (expired) state <= (left == '0) ? ST_CLR_WE : ST_WRITE;
                ST_WRITE: begin
                    idx   <= idx + 1'b1;
                    left  <= left - 1'b1;
                    state <= ST_WAIT_WORD;
                end
                ST_WAIT_WORD:
                    if (expired) state <= (left == '0) ? ST_CLR_WE : ST_WRITE;
                ST_CLR_WE: begin
                    shadow <= with_we(shadow, 1'b0);
                    state  <= ST_WAIT_DIS;
                end
                ST_WAIT_DIS:
                    if (expired) state <= ST_DONE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        req      = '0;
        tmr_load = 1'b0;
        tmr_val  = EN_LOAD;
        fifo_pop = 1'b0;
        case (state)
            ST_SET_WE: begin
                req      = '{wr: 1'b1, addr: CTL_ADDR, data: with_we(shadow, 1'b1)};
                tmr_load = 1'b1;
            end
            ST_WRITE: begin
                req      = '{wr: 1'b1, addr: window_addr(16'(idx)), data: fifo_head};
                tmr_load = 1'b1;
                tmr_val  = WORD_LOAD;
                fifo_pop = 1'b1;
            end
            ST_CLR_WE: begin
                req      = '{wr: 1'b1, addr: CTL_ADDR, data: with_we(shadow, 1'b0)};
                tmr_load = 1'b1;
            end
            default: ;
        endcase
    end

    assign busy = (state != ST_IDLE);
    assign done = (state == ST_DONE);
endmodule

// File: rtl/cfg_rom_prog.sv
module cfg_rom_prog
    import cfgprog_pkg::*;
#(
    parameter int          IDX_W       = 6,
    parameter int          FIFO_DEPTH  = 8,
    parameter int          CNT_W       = 4,
    parameter int unsigned ENABLE_WAIT = 50_000_000,
    parameter int unsigned WORD_WAIT   = 2_000_000,
    parameter logic [15:0] CTL_ADDR    = 16'h0088,
    parameter logic [15:0] CTL_INIT    = 16'h0000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_push,
    input  logic [15:0]      load_word,
    input  logic             start,
    input  logic [IDX_W-1:0] start_index,
    input  logic [CNT_W-1:0] word_total,
    output logic             bus_wr,
    output logic [15:0]      bus_addr,
    output logic [15:0]      bus_wdata,
    output logic             busy,
    output logic             done
);
    localparam int unsigned LONGEST = (ENABLE_WAIT > WORD_WAIT) ? ENABLE_WAIT : WORD_WAIT;
    localparam int          TMR_W   = $clog2(LONGEST + 1);

    logic             tmr_load, expired, fifo_pop;
    logic [TMR_W-1:0] tmr_val;
    logic [15:0]      fifo_head;
    bus_req_t         req;

    cfgprog_fifo #(.DEPTH(FIFO_DEPTH), .W(16)) u_fifo (
        .clk(clk), .rst(rst), .push(load_push), .push_data(load_word),
        .pop(fifo_pop), .head(fifo_head)
    );

    cfgprog_timer #(.W(TMR_W)) u_timer (
        .clk(clk), .rst(rst), .load(tmr_load), .load_val(tmr_val), .expired(expired)
    );

    cfgprog_fsm #(
        .IDX_W(IDX_W), .CNT_W(CNT_W), .TMR_W(TMR_W),
        .ENABLE_WAIT(ENABLE_WAIT), .WORD_WAIT(WORD_WAIT),
        .CTL_ADDR(CTL_ADDR), .CTL_INIT(CTL_INIT)
    ) u_fsm (
        .clk(clk), .rst(rst), .start(start), .start_index(start_index),
        .word_total(word_total), .expired(expired), .fifo_head(fifo_head),
        .tmr_load(tmr_load), .tmr_val(tmr_val), .fifo_pop(fifo_pop),
        .req(req), .busy(busy), .done(done)
    );

    assign bus_wr    = req.wr;
    assign bus_addr  = req.addr;
    assign bus_wdata = req.data;
endmodule

// File: rtl/cfgprog_chk.sv
module cfgprog_chk #(
    parameter logic [15:0] CTL_ADDR = 16'h0088,
    parameter logic [15:0] CTL_INIT = 16'h0000
) (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        bus_wr,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic        busy,
    input logic        done
);
    p_first_enable_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> (bus_wr && bus_addr == CTL_ADDR && bus_wdata[4]));

    p_window_even_r4: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr != CTL_ADDR) |-> (!bus_addr[0] && bus_addr >= 16'h1000));

    p_ctl_bits_kept_r6: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == CTL_ADDR) |-> (((bus_wdata ^ CTL_INIT) & ~16'h0010) == 16'h0000));

    p_done_single_r7: assert property (@(posedge clk) disable iff (rst)
        done |=> (!done && !busy));

    p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
        (busy && !done && start) |=> busy);

    p_wr_single_r10: assert property (@(posedge clk) disable iff (rst)
        bus_wr |=> !bus_wr);

    p_idle_no_wr_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !bus_wr);
endmodule

bind cfg_rom_prog cfgprog_chk #(.CTL_ADDR(CTL_ADDR), .CTL_INIT(CTL_INIT)) u_chk (
    .clk(clk), .rst(rst), .start(start), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .busy(busy), .done(done)
);

// File: tb/cfg_rom_prog_tb_top.sv
`timescale 1ns/1ps
module cfg_rom_prog_tb_top;
    localparam int          IDX_W = 6;
    localparam int          DEPTH = 4;
    localparam int          CNT_W = 3;
    localparam int          EW    = 6;
    localparam int          WW    = 3;
    localparam logic [15:0] CADDR = 16'h0088;
    localparam logic [15:0] CINIT = 16'hA5C3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             load_push = 1'b0;
    logic [15:0]      load_word = '0;
    logic             start = 1'b0;
    logic [IDX_W-1:0] start_index = '0;
    logic [CNT_W-1:0] word_total = '0;
    logic             bus_wr, busy, done;
    logic [15:0]      bus_addr, bus_wdata;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 0;

    int          wr_n = 0;
    logic [15:0] log_addr [16];
    logic [15:0] log_data [16];
    int          log_cyc  [16];
    int          done_n = 0;
    int          done_at = 0;

    always #2.5 clk = ~clk;

    cfg_rom_prog #(
        .IDX_W(IDX_W), .FIFO_DEPTH(DEPTH), .CNT_W(CNT_W),
        .ENABLE_WAIT(EW), .WORD_WAIT(WW), .CTL_ADDR(CADDR), .CTL_INIT(CINIT)
    ) dut_i (
        .clk(clk), .rst(rst), .load_push(load_push), .load_word(load_word),
        .start(start), .start_index(start_index), .word_total(word_total),
        .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .busy(busy), .done(done)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (!rst && bus_wr) begin
            if (wr_n < 16) begin
                log_addr[wr_n] = bus_addr;
                log_data[wr_n] = bus_wdata;
                log_cyc[wr_n]  = cyc;
            end
            wr_n = wr_n + 1;
        end
        if (!rst && done) begin
            done_n  = done_n + 1;
            done_at = cyc;
        end
    end

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] word_of(input int n, input int idx, input int k);
        return 16'((n * 16'h1111) ^ (idx * 16'h0107) ^ (k * 16'h2203) ^ 16'h5A00);
    endfunction

    task automatic wait_cyc(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic run_case(input int n, input int idx);
        int sc;
        int d_exp;
        int t;
        wr_n = 0;
        done_n = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            load_push = 1'b1;
            load_word = word_of(n, idx, k);
        end
        @(negedge clk);
        load_push = 1'b0;
        sc = cyc;
        start = 1'b1;
        start_index = IDX_W'(idx);
        word_total = CNT_W'(n);
        @(negedge clk);
        start = 1'b0;
        check("R2 busy after start", busy, 1);
        @(negedge clk);
        // R9: start while the session runs
        start = 1'b1;
        start_index = IDX_W'(idx ^ 5);
        word_total = CNT_W'(DEPTH);
        @(negedge clk);
        start = 1'b0;
        d_exp = sc + 1 + 2 * EW + n * WW;
        wait_cyc(d_exp);
        // R9: start in the done cycle
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_cyc(d_exp + 1);
        check("R7 busy low after done", busy, 0);
        wait_cyc(d_exp + 2 * EW + 4);
        check("R9 write count", wr_n, n + 2);
        check("R7 done count", done_n, 1);
        check("R7 done cycle", done_at, d_exp);
        if (wr_n == n + 2) begin
            check("R2 enable addr", log_addr[0], CADDR);
            check("R2 enable data", log_data[0], CINIT | 16'h0010);
            check("R2 enable cycle", log_cyc[0], sc + 1);
            for (int k = 0; k < n; k++) begin
                t = sc + 1 + EW + k * WW;
                check("R4 data addr", log_addr[k + 1], 16'h1000 + 2 * ((idx + k) % 64));
                check("R4 data word", log_data[k + 1], word_of(n, idx, k));
                check(k == 0 ? "R3 first data cycle" : "R5 data spacing", log_cyc[k + 1], t);
            end
            check("R6 disable addr", log_addr[n + 1], CADDR);
            check("R6 disable data", log_data[n + 1], CINIT & ~16'h0010);
            check(n == 0 ? "R8 zero count disable cycle" : "R5 disable cycle",
                  log_cyc[n + 1], sc + 1 + EW + n * WW);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 busy reset", busy, 0);
        check("R1 done reset", done, 0);
        check("R1 bus_wr reset", bus_wr, 0);
        for (int n = 0; n <= DEPTH; n++) begin
            run_case(n, 0);
            run_case(n, 17);
            run_case(n, 62);
            run_case(n, 63);
        end
        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL R7 watchdog actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule